// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block is a watchdog counter advanced by strobes from a low-speed clock and serviced by software through an 8-bit control write port. The counter can only be cleared by a two-byte key sequence. The first key byte arms a readable one-bit pointer, and the second byte, given while the pointer is armed, clears the counter and disarms the pointer. A separate mode write port chooses one of four overflow periods. Writing the mode also restarts the count.

Failure to service escalates in two stages. The first overflow since the last clear produces a one-cycle interrupt together with a wake request for halt modes. A further overflow with no clear in between raises a reset request, which stays high until the block itself is reset. A successful clear opens a short window that lasts until the next low-speed strobe. During that window, key writes are ignored and the counter does not advance. The count also holds while the oscillator is not yet reported ready, and while the stop-mode input is high.

Top module: `wdt_keyed_top`

## Requirements
- R1: The counter advances only on a cycle with `slow_tick` high, `rst_n` released and `osc_ready` high; ticks while `osc_ready` is low leave `count` unchanged.
- R2: With `period_sel` = s, the counter runs from 0 up to 2^(7+2s)−1, and the next counted tick returns it to 0 and is an overflow. A `wr_mode` write loads `wdata[1:0]` into `period_sel` and zeroes `count` on the next edge.
- R3: A control write of 8'h5A while `key_ptr` is 0 sets `key_ptr` to 1 on the next edge.
- R4: A control write of 8'hA5 while `key_ptr` is 1 zeroes `count`, returns `key_ptr` to 0 and forgets any earlier overflow, so the next overflow is again a first one.
- R5: Any other control write leaves `key_ptr` and `count` unchanged. This includes 8'hA5 at pointer 0, 8'h5A at pointer 1, and any other byte.
- R6: The first overflow since reset or since the last clear gives a one-cycle pulse on `wdt_irq` and `wake_req` in the cycle after the overflowing tick.
- R7: An overflow after that first one, with no clear between them, sets `wdt_rst_req`, which stays high until `rst_n` is asserted and is not removed by a key clear.
- R8: After a clear, control writes are ignored and ticks are not counted until the next `slow_tick`. That strobe only ends the window and does not increment the counter.
- R9: While `stop_mode` is high, `count` holds its value.
- R10: After reset, `count`, `key_ptr`, `period_sel`, `wdt_irq`, `wake_req` and `wdt_rst_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| osc_ready | input | 1 | Low-speed oscillator reported running |
| slow_tick | input | 1 | One-cycle strobe per low-speed clock period |
| stop_mode | input | 1 | Freezes the counter while high |
| wr_ctl | input | 1 | Control (key) register write strobe |
| wr_mode | input | 1 | Mode register write strobe |
| wdata | input | 8 | Write data for both registers |
| key_ptr | output | 1 | Readable key sequence pointer |
| period_sel | output | 2 | Selected overflow period |
| count | output | 13 | Current counter value |
| wdt_irq | output | 1 | First-overflow interrupt pulse |
| wake_req | output | 1 | Halt-release request, pulsed with the interrupt |
| wdt_rst_req | output | 1 | Sticky system reset request |

## Verification
The in-line properties check the following on every cycle: pointer arming, pointer stability during the clear window, the counter holding when not enabled, the counter staying within the selected period, the single-cycle interrupt, and the sticky reset request. Some behaviours need a history that only the bench's scenarios build up. These are the exact tick count to an overflow for each period, the interrupt-then-reset escalation, the forgetting of the first overflow after a clear, and the rejection of mismatched key bytes. The bench's reference model and directed cases cover these.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
   localparam logic [7:0] KEY_ARM  = 8'h5A;
   localparam logic [7:0] KEY_FIRE = 8'hA5;

   typedef enum logic {
      PTR_IDLE  = 1'b0,
      PTR_ARMED = 1'b1
   } key_ptr_e;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
   import wdt_keyed_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_ctl,
   input  logic [7:0] wdata,
   input  logic       tick,
   output logic       ptr_o,
   output logic       busy_o,
   output logic       clr_o
);
   key_ptr_e ptr_q;
   logic     busy_q;
   logic     arm;

   assign arm   = wr_ctl && !busy_q && (ptr_q == PTR_IDLE)  && (wdata == KEY_ARM);
   assign clr_o = wr_ctl && !busy_q && (ptr_q == PTR_ARMED) && (wdata == KEY_FIRE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= PTR_IDLE;
         busy_q <= 1'b0;
      end else begin
         if (clr_o)
            ptr_q <= PTR_IDLE;
         else if (arm)
            ptr_q <= PTR_ARMED;
         if (clr_o)
            busy_q <= 1'b1;
         else if (tick)
            busy_q <= 1'b0;
      end
   end

   assign ptr_o  = (ptr_q == PTR_ARMED);
   assign busy_o = busy_q;

   AST_PTR_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && !busy_o && !ptr_o && wdata == KEY_ARM) |=> ptr_o); // R3
   AST_WINDOW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(ptr_o)); // R8
   AST_WRONG_KEY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && !busy_o && ptr_o && wdata != KEY_FIRE) |=> ptr_o); // R5
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int BASE_EXP    = 7,
   parameter int STEP_EXP    = 2,
   parameter int NUM_PERIODS = 4,
   localparam int SEL_W = (NUM_PERIODS > 1) ? $clog2(NUM_PERIODS) : 1,
   localparam int CNT_W = BASE_EXP + STEP_EXP * (NUM_PERIODS - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic             tick,
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);
   logic [CNT_W-1:0] term_arr [NUM_PERIODS];
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term;

   for (genvar i = 0; i < NUM_PERIODS; i++) begin : g_term
      localparam int E = BASE_EXP + STEP_EXP * i;
      assign term_arr[i] = CNT_W'((64'd1 << E) - 64'd1);
   end

   assign term  = term_arr[sel];
   assign ovf_o = !clr && run && tick && (cnt_q == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (run && tick)
         cnt_q <= ovf_o ? '0 : cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   AST_NO_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !(run && tick)) |=> $stable(cnt_o)); // R9
   AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_o <= term); // R2
   AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_o == '0)); // R4
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic ovf,
   output logic irq_o,
   output logic rst_req_o
);
   logic first_q;
   logic irq_q;
   logic rst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= 1'b0;
         irq_q   <= 1'b0;
         rst_q   <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (clr)
            first_q <= 1'b0;
         else if (ovf) begin
            if (first_q)
               rst_q <= 1'b1;
            else begin
               first_q <= 1'b1;
               irq_q   <= 1'b1;
            end
         end
      end
   end

   assign irq_o     = irq_q;
   assign rst_req_o = rst_q;

   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o); // R6
   AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> rst_req_o); // R7
   AST_NO_EARLY_RST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req_o) |-> !irq_o); // R7
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top #(
   parameter int BASE_EXP    = 7,
   parameter int STEP_EXP    = 2,
   parameter int NUM_PERIODS = 4,
   localparam int SEL_W = (NUM_PERIODS > 1) ? $clog2(NUM_PERIODS) : 1,
   localparam int CNT_W = BASE_EXP + STEP_EXP * (NUM_PERIODS - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_ready,
   input  logic             slow_tick,
   input  logic             stop_mode,
   input  logic             wr_ctl,
   input  logic             wr_mode,
   input  logic [7:0]       wdata,
   output logic             key_ptr,
   output logic [SEL_W-1:0] period_sel,
   output logic [CNT_W-1:0] count,
   output logic             wdt_irq,
   output logic             wake_req,
   output logic             wdt_rst_req
);
   if (BASE_EXP < 1 || STEP_EXP < 1) begin : g_bad_exp
      $error("wdt_keyed_top: exponents must be positive");
   end
   if (NUM_PERIODS < 2 || NUM_PERIODS != (1 << SEL_W)) begin : g_bad_num
      $error("wdt_keyed_top: NUM_PERIODS must be a power of two of at least 2");
   end
   if (SEL_W > 8 || CNT_W > 63) begin : g_bad_width
      $error("wdt_keyed_top: selector or counter too wide");
   end

   logic             busy;
   logic             key_clr;
   logic             ovf;
   logic             run;
   logic [SEL_W-1:0] sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_q <= '0;
      else if (wr_mode)
         sel_q <= wdata[SEL_W-1:0];
   end

   assign run = osc_ready && !stop_mode && !busy;

   wdt_key_seq u_keys (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_ctl (wr_ctl),
      .wdata  (wdata),
      .tick   (slow_tick),
      .ptr_o  (key_ptr),
      .busy_o (busy),
      .clr_o  (key_clr)
   );

   wdt_counter #(
      .BASE_EXP    (BASE_EXP),
      .STEP_EXP    (STEP_EXP),
      .NUM_PERIODS (NUM_PERIODS)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (key_clr || wr_mode),
      .run   (run),
      .tick  (slow_tick),
      .sel   (sel_q),
      .cnt_o (count),
      .ovf_o (ovf)
   );

   wdt_escalate u_esc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (key_clr),
      .ovf       (ovf),
      .irq_o     (wdt_irq),
      .rst_req_o (wdt_rst_req)
   );

   assign period_sel = sel_q;
   assign wake_req   = wdt_irq;

   AST_OSC_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_ready && !wr_mode && !wr_ctl) |=> $stable(count)); // R1
   AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_mode && !wr_mode && !wr_ctl) |=> $stable(count)); // R9
   AST_MODE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mode |=> (count == '0)); // R2
endmodule

// File: tb/wdt_keyed_top_tb.sv
`timescale 1ns/1ps
module wdt_keyed_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        osc_ready = 1'b0;
   logic        slow_tick = 1'b0;
   logic        stop_mode = 1'b0;
   logic        wr_ctl = 1'b0;
   logic        wr_mode = 1'b0;
   logic [7:0]  wdata = 8'h00;
   logic        key_ptr;
   logic [1:0]  period_sel;
   logic [12:0] count;
   logic        wdt_irq;
   logic        wake_req;
   logic        wdt_rst_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   wdt_keyed_top dut_i (
      .clk(clk), .rst_n(rst_n), .osc_ready(osc_ready), .slow_tick(slow_tick),
      .stop_mode(stop_mode), .wr_ctl(wr_ctl), .wr_mode(wr_mode), .wdata(wdata),
      .key_ptr(key_ptr), .period_sel(period_sel), .count(count),
      .wdt_irq(wdt_irq), .wake_req(wake_req), .wdt_rst_req(wdt_rst_req)
   );

   // reference model derived from the requirements
   logic        m_ptr, m_busy, m_first, m_irq, m_rst;
   logic [1:0]  m_sel;
   logic [12:0] m_cnt;

   function automatic logic [12:0] f_last(input logic [1:0] s);
      return 13'((32'd1 << (7 + 2 * s)) - 1);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ptr <= 0; m_busy <= 0; m_first <= 0; m_irq <= 0; m_rst <= 0;
         m_sel <= 0; m_cnt <= 0;
      end else begin
         logic kclr, karm, run, ovf;
         kclr = wr_ctl && !m_busy && m_ptr && wdata == 8'hA5;
         karm = wr_ctl && !m_busy && !m_ptr && wdata == 8'h5A;
         run  = osc_ready && !stop_mode && !m_busy;
         ovf  = !(kclr || wr_mode) && run && slow_tick && m_cnt == f_last(m_sel);
         if (kclr) m_ptr <= 0; else if (karm) m_ptr <= 1;
         if (kclr) m_busy <= 1; else if (slow_tick) m_busy <= 0;
         if (kclr || wr_mode) m_cnt <= 0;
         else if (run && slow_tick) m_cnt <= ovf ? 13'd0 : m_cnt + 13'd1;
         if (wr_mode) m_sel <= wdata[1:0];
         m_irq <= ovf && !m_first;
         if (kclr) m_first <= 0; else if (ovf) m_first <= 1;
         if (ovf && m_first) m_rst <= 1;
      end
   end

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic scoreboard();
      chk("R2 count vs model", count, m_cnt);
      chk("R3 key_ptr vs model", key_ptr, m_ptr);
      chk("R6 wdt_irq vs model", wdt_irq, m_irq);
      chk("R6 wake_req vs model", wake_req, m_irq);
      chk("R7 wdt_rst_req vs model", wdt_rst_req, m_rst);
      chk("R2 period_sel vs model", period_sel, m_sel);
   endtask

   task automatic cyc(input logic t, input logic wc, input logic wm, input logic [7:0] d);
      slow_tick = t; wr_ctl = wc; wr_mode = wm; wdata = d;
      @(negedge clk);
      slow_tick = 0; wr_ctl = 0; wr_mode = 0;
      scoreboard();
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic do_reset();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic service();
      cyc(1'b0, 1'b1, 1'b0, 8'h5A);
      cyc(1'b0, 1'b1, 1'b0, 8'hA5);
      ticks(1);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      do_reset();
      // r10_ reset state
      chk("R10 count", count, 0);
      chk("R10 key_ptr", key_ptr, 0);
      chk("R10 period_sel", period_sel, 0);
      chk("R10 irq", wdt_irq, 0);
      chk("R10 rst_req", wdt_rst_req, 0);

      // R1: oscillator not ready
      ticks(20);
      chk("R1 no count before osc", count, 0);
      osc_ready = 1;
      ticks(5);
      chk("R1 counts after osc", count, 5);

      // R5 wrong bytes
      cyc(1'b0, 1'b1, 1'b0, 8'hA5);
      chk("R5 A5 at ptr0", key_ptr, 0);
      chk("R5 count kept", count, 5);
      cyc(1'b0, 1'b1, 1'b0, 8'h33);
      chk("R5 other byte", key_ptr, 0);
      // R3
      cyc(1'b0, 1'b1, 1'b0, 8'h5A);
      chk("R3 arm", key_ptr, 1);
      cyc(1'b0, 1'b1, 1'b0, 8'h5A);
      chk("R5 5A at ptr1", key_ptr, 1);
      chk("R5 count kept at ptr1", count, 5);
      // R4
      cyc(1'b0, 1'b1, 1'b0, 8'hA5);
      chk("R4 ptr back", key_ptr, 0);
      chk("R4 count zero", count, 0);
      // R8 window
      cyc(1'b0, 1'b1, 1'b0, 8'h5A);
      chk("R8 write ignored", key_ptr, 0);
      ticks(1);
      chk("R8 ending tick not counted", count, 0);
      ticks(1);
      chk("R8 counting resumes", count, 1);
      // R9 stop
      stop_mode = 1;
      ticks(10);
      chk("R9 frozen", count, 1);
      stop_mode = 0;

      // R6 / R7 escalation at period 0
      service();
      ticks(127);
      chk("R2 last value", count, 127);
      chk("R6 no irq yet", wdt_irq, 0);
      ticks(1);
      chk("R6 irq", wdt_irq, 1);
      chk("R6 wake", wake_req, 1);
      chk("R2 wrap", count, 0);
      cyc(1'b0, 1'b0, 1'b0, 8'h00);
      chk("R6 pulse ends", wdt_irq, 0);
      ticks(128);
      chk("R7 reset request", wdt_rst_req, 1);
      chk("R7 no second irq", wdt_irq, 0);
      service();
      chk("R7 sticky over clear", wdt_rst_req, 1);
      do_reset();
      chk("R7 cleared by reset", wdt_rst_req, 0);

      // R4: clear forgets first overflow
      ticks(128);
      chk("R6 first after reset", wdt_irq, 1);
      service();
      ticks(128);
      chk("R4 irq again after clear", wdt_irq, 1);
      chk("R4 no reset request", wdt_rst_req, 0);

      // R2 period 1 and mode restart
      ticks(30);
      cyc(1'b0, 1'b0, 1'b1, 8'h01);
      chk("R2 mode restart", count, 0);
      chk("R2 period_sel", period_sel, 1);
      ticks(511);
      chk("R2 period1 last", count, 511);
      ticks(1);
      chk("R2 period1 wrap", count, 0);

      // random phase against the model
      do_reset();
      for (int c = 0; c < 40000; c++) begin
         logic t, wc, wm;
         logic [7:0] d;
         if (c % 8000 == 7999) do_reset();
         osc_ready = ($urandom % 50) != 0;
         stop_mode = ($urandom % 40) == 0;
         t  = ($urandom % 3) == 0;
         wc = ($urandom % 150) == 0;
         wm = !wc && ($urandom % 5000) == 0;
         case ($urandom % 4)
            0: d = 8'h5A;
            1: d = 8'hA5;
            2: d = 8'($urandom);
            default: d = 8'h5A;
         endcase
         if (wm) d = 8'($urandom % 2);
         cyc(t, wc, wm, d);
      end
      stop_mode = 0;

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired: got hang expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule